// File: doc/BRIEF.md
# Open-Row-First DRAM Command Scheduler

This block sits between a request source and a multi-bank DRAM command bus. It takes read and write requests through a valid/ready handshake and keeps up to eight of them pending. Each request names a bank, a row and a column. On every cycle the block picks at most one legal command for the DRAM and registers it onto the command bus. The command is a precharge, a row activate, a read or a write. The block tracks for every bank whether a row is open, which row that is, and how long the bank must wait before its next command.

Two scheduling policies are available. In in-order mode only the oldest pending request may drive commands, so column accesses leave in arrival order. In open-row-first mode any pending request may act. A request whose row is already open is served ahead of older requests that still need a precharge or an activate. While one bank waits out a timing gap, another bank can receive its precharge or activate, so their latencies overlap. The policy input may be changed only while the queue is empty.

Row and column addresses share one address field. An activate carries the row and a column access carries the column.

Top module: `dram_sched`

## Requirements
- R1: While reset is asserted and directly after it, the command output is NOP (code 0), the command bank and address are zero, and `req_ready_o` is high.
- R2: A read (code 3) or write (code 4) is issued for a request only when its bank holds that request's row open. Each request produces exactly one column command, and the request then leaves the queue.
- R3: A request to a bank with a different row open first gets a precharge (code 1, address 0). A request to a closed bank gets an activate (code 2) that carries the row on `cmd_addr_o`. A column command carries the column, zero-extended, on `cmd_addr_o`.
- R4: A bank's activate comes at least T_RP+1 cycles after its precharge. A column command comes at least T_RCD+1 cycles after its activate. Both gaps are set by a per-bank down-counter that must reach zero.
- R5: With `mode_orf_i` low, only the oldest pending request issues commands, so column commands follow arrival order.
- R6: With `mode_orf_i` high, a ready request that hits an open row is chosen before any older request that needs a precharge or an activate.
- R7: Among candidates of the same class (hit or non-hit), the oldest request is chosen.
- R8: With `mode_orf_i` high, when older requests' banks are still counting down, a ready command for another bank is issued in that cycle.
- R9: The queue holds 8 requests. `req_ready_o` is low exactly when 8 requests are pending, and a request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both high.
- R10: `mode_orf_i` changes only while the queue is empty. The policy then applies to every request accepted afterwards.
- R11: The chosen command appears on the outputs one clock after the state it was chosen from. When no command is legal, the output is NOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| mode_orf_i | input | 1 | 1 selects open-row-first, 0 selects in-order |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Queue has room |
| req_bank_i | input | BANK_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Target column |
| req_write_i | input | 1 | 1 for write, 0 for read |
| cmd_o | output | 3 | 0 NOP, 1 precharge, 2 activate, 3 read, 4 write |
| cmd_bank_o | output | BANK_W | Bank of the command |
| cmd_addr_o | output | ADDR_W | Row on activate, column on read/write, else 0 |

## Verification
The hardest case to reach is a choice that involves several requests at once. A younger hit must sit in the queue next to an older miss to the same bank at the moment that bank's counter reaches zero. A different bank must be idle while the chosen bank is still counting down. The stimulus first sends one miss to force a precharge on a bank. It then queues a conflicting row and a matching row behind that miss during the precharge gap. This puts hit and miss side by side for the decision after the activate. The overlap case follows the same pattern: an activate to a closed bank is followed at once by a request for another bank that has a stale row open. Long random runs confined to a few rows then fill the queue and mix both classes, and a behavioural model is compared on every cycle.

// File: rtl/dsch_pkg.sv
package dsch_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } dcmd_e;
endpackage

// File: rtl/dsch_bank.sv
module dsch_bank #(
  parameter int ROW_W = 8,
  parameter int TMR_W = 2,
  parameter int T_RP  = 2,
  parameter int T_RCD = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_pre_i,
  input  logic             do_act_i,
  input  logic             do_col_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             idle_o
);
  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q;
  logic [TMR_W-1:0] tmr_q, tmr_d;

  always_comb begin
    open_d = open_q;
    tmr_d  = (tmr_q != '0) ? tmr_q - 1'b1 : tmr_q;
    if (do_pre_i) begin
      open_d = 1'b0;
      tmr_d  = TMR_W'(T_RP);
    end else if (do_act_i) begin
      open_d = 1'b1;
      tmr_d  = TMR_W'(T_RCD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      tmr_q  <= '0;
    end else begin
      open_q <= open_d;
      tmr_q  <= tmr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_act_i) row_q <= row_i;
  end

  assign open_o = open_q;
  assign row_o  = row_q;
  assign idle_o = (tmr_q == '0);

  // R2
  col_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_col_i |-> (open_q && row_q == row_i && tmr_q == '0));
  // R4
  act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_act_i |-> (!open_q && tmr_q == '0));
  // R3
  pre_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_pre_i |-> (open_q && tmr_q == '0));
endmodule

// File: rtl/dsch_queue.sv
module dsch_queue #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             enq_i,
  input  logic [BANK_W-1:0]                enq_bank_i,
  input  logic [ROW_W-1:0]                 enq_row_i,
  input  logic [COL_W-1:0]                 enq_col_i,
  input  logic                             enq_we_i,
  input  logic                             deq_i,
  input  logic [IDX_W-1:0]                 deq_idx_i,
  output logic [DEPTH-1:0]                 vld_o,
  output logic [DEPTH-1:0][BANK_W-1:0]     bank_o,
  output logic [DEPTH-1:0][ROW_W-1:0]      row_o,
  output logic [DEPTH-1:0][COL_W-1:0]      col_o,
  output logic [DEPTH-1:0]                 we_o,
  output logic [DEPTH-1:0][IDX_W-1:0]      age_o,
  output logic                             full_o,
  output logic                             empty_o
);
  logic [DEPTH-1:0]            vld_q, vld_d;
  logic [DEPTH-1:0][IDX_W-1:0] age_q, age_d;
  logic [DEPTH-1:0][BANK_W-1:0] bank_q;
  logic [DEPTH-1:0][ROW_W-1:0]  row_q;
  logic [DEPTH-1:0][COL_W-1:0]  col_q;
  logic [DEPTH-1:0]             we_q;
  logic [CNT_W-1:0]             cnt_q, cnt_d, cnt_left;
  logic [IDX_W-1:0]             free_idx, deq_age;
  logic                         free_found;
  logic [DEPTH-1:0]             load;
  logic [DEPTH-1:0]             head_vec;

  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !free_found) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  assign deq_age  = age_q[deq_idx_i];
  assign cnt_left = cnt_q - CNT_W'(deq_i);

  always_comb begin
    cnt_d = cnt_left + CNT_W'(enq_i);
    for (int i = 0; i < DEPTH; i++) begin
      vld_d[i] = vld_q[i];
      age_d[i] = age_q[i];
      load[i]  = enq_i && (free_idx == IDX_W'(i));
      if (deq_i && deq_idx_i == IDX_W'(i)) begin
        vld_d[i] = 1'b0;
      end else if (deq_i && vld_q[i] && age_q[i] > deq_age) begin
        age_d[i] = age_q[i] - 1'b1;
      end
      if (load[i]) begin
        vld_d[i] = 1'b1;
        age_d[i] = IDX_W'(cnt_left);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      age_q <= '0;
      cnt_q <= '0;
    end else begin
      vld_q <= vld_d;
      age_q <= age_d;
      cnt_q <= cnt_d;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (load[g]) begin
          bank_q[g] <= enq_bank_i;
          row_q[g]  <= enq_row_i;
          col_q[g]  <= enq_col_i;
          we_q[g]   <= enq_we_i;
        end
      end
      assign head_vec[g] = vld_q[g] && (age_q[g] == '0);
    end
  endgenerate

  assign vld_o   = vld_q;
  assign bank_o  = bank_q;
  assign row_o   = row_q;
  assign col_o   = col_q;
  assign we_o    = we_q;
  assign age_o   = age_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == int'(cnt_q));
  // R7
  oldest_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|vld_q) |-> ($countones(head_vec) == 1));
  // R2
  deq_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deq_i |-> vld_q[deq_idx_i]);
endmodule

// File: rtl/dsch_pick.sv
module dsch_pick
  import dsch_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 8,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic                              orf_i,
  input  logic [DEPTH-1:0]                  vld_i,
  input  logic [DEPTH-1:0][BANK_W-1:0]      bank_i,
  input  logic [DEPTH-1:0][ROW_W-1:0]       row_i,
  input  logic [DEPTH-1:0]                  we_i,
  input  logic [DEPTH-1:0][IDX_W-1:0]       age_i,
  input  logic [NUM_BANKS-1:0]              open_i,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0]   orow_i,
  input  logic [NUM_BANKS-1:0]              idle_i,
  output logic                              sel_vld_o,
  output logic [IDX_W-1:0]                  sel_idx_o,
  output dcmd_e                             sel_cmd_o
);
  logic [DEPTH-1:0] hit, rdy;
  logic             h_found, a_found;
  logic [IDX_W-1:0] h_idx, a_idx, h_age, a_age, s_idx;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hit[i] = open_i[bank_i[i]] && (orow_i[bank_i[i]] == row_i[i]);
      rdy[i] = vld_i[i] && idle_i[bank_i[i]] && (orf_i || age_i[i] == '0);
    end
  end

  // two age-ordered searches: open-row hits first, then any ready entry
  always_comb begin
    h_found = 1'b0; h_idx = '0; h_age = '0;
    a_found = 1'b0; a_idx = '0; a_age = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rdy[i] && hit[i] && (!h_found || age_i[i] < h_age)) begin
        h_found = 1'b1; h_idx = IDX_W'(i); h_age = age_i[i];
      end
      if (rdy[i] && (!a_found || age_i[i] < a_age)) begin
        a_found = 1'b1; a_idx = IDX_W'(i); a_age = age_i[i];
      end
    end
    s_idx = h_found ? h_idx : a_idx;
  end

  always_comb begin
    if (!a_found)                 sel_cmd_o = CMD_NOP;
    else if (hit[s_idx])          sel_cmd_o = we_i[s_idx] ? CMD_WR : CMD_RD;
    else if (open_i[bank_i[s_idx]]) sel_cmd_o = CMD_PRE;
    else                          sel_cmd_o = CMD_ACT;
  end

  assign sel_vld_o = a_found;
  assign sel_idx_o = s_idx;
endmodule

// File: rtl/dram_sched.sv
module dram_sched
  import dsch_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DEPTH     = 8,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int T_RP      = 2,
  parameter int T_RCD     = 3,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_orf_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_write_i,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int TMAX  = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int TMR_W = $clog2(TMAX + 2);

  logic [DEPTH-1:0]                q_vld, q_we;
  logic [DEPTH-1:0][BANK_W-1:0]    q_bank;
  logic [DEPTH-1:0][ROW_W-1:0]     q_row;
  logic [DEPTH-1:0][COL_W-1:0]     q_col;
  logic [DEPTH-1:0][IDX_W-1:0]     q_age;
  logic                            q_full, q_empty, enq, deq;
  logic [NUM_BANKS-1:0]            b_open, b_idle, do_pre, do_act, do_col;
  logic [NUM_BANKS-1:0][ROW_W-1:0] b_row;
  logic                            sel_vld;
  logic [IDX_W-1:0]                sel_idx;
  dcmd_e                           sel_cmd;
  logic [BANK_W-1:0]               sel_bank;
  logic [ROW_W-1:0]                sel_row;
  logic [COL_W-1:0]                sel_col;
  logic [2:0]                      cmd_q, cmd_d;
  logic [BANK_W-1:0]               bank_q, bank_d;
  logic [ADDR_W-1:0]               addr_q, addr_d;

  assign req_ready_o = !q_full;
  assign enq         = req_valid_i && !q_full;

  dsch_queue #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .enq_i(enq), .enq_bank_i(req_bank_i), .enq_row_i(req_row_i),
    .enq_col_i(req_col_i), .enq_we_i(req_write_i),
    .deq_i(deq), .deq_idx_i(sel_idx),
    .vld_o(q_vld), .bank_o(q_bank), .row_o(q_row), .col_o(q_col),
    .we_o(q_we), .age_o(q_age), .full_o(q_full), .empty_o(q_empty)
  );

  dsch_pick #(.DEPTH(DEPTH), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_pick (
    .orf_i(mode_orf_i), .vld_i(q_vld), .bank_i(q_bank), .row_i(q_row),
    .we_i(q_we), .age_i(q_age), .open_i(b_open), .orow_i(b_row), .idle_i(b_idle),
    .sel_vld_o(sel_vld), .sel_idx_o(sel_idx), .sel_cmd_o(sel_cmd)
  );

  assign sel_bank = q_bank[sel_idx];
  assign sel_row  = q_row[sel_idx];
  assign sel_col  = q_col[sel_idx];
  assign deq      = sel_vld && (sel_cmd == CMD_RD || sel_cmd == CMD_WR);

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign do_pre[b] = sel_vld && sel_cmd == CMD_PRE && sel_bank == BANK_W'(b);
      assign do_act[b] = sel_vld && sel_cmd == CMD_ACT && sel_bank == BANK_W'(b);
      assign do_col[b] = deq && sel_bank == BANK_W'(b);
      dsch_bank #(.ROW_W(ROW_W), .TMR_W(TMR_W), .T_RP(T_RP), .T_RCD(T_RCD)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .do_pre_i(do_pre[b]), .do_act_i(do_act[b]), .do_col_i(do_col[b]),
        .row_i(sel_row), .open_o(b_open[b]), .row_o(b_row[b]), .idle_o(b_idle[b])
      );
    end
  endgenerate

  // one multiplexed address field: row with activate, column with access
  always_comb begin
    cmd_d  = sel_vld ? sel_cmd : CMD_NOP;
    bank_d = sel_vld ? sel_bank : '0;
    case (cmd_d)
      CMD_ACT:        addr_d = ADDR_W'(sel_row);
      CMD_RD, CMD_WR: addr_d = ADDR_W'(sel_col);
      default:        addr_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      addr_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      bank_q <= bank_d;
      addr_q <= addr_d;
    end
  end

  assign cmd_o      = cmd_q;
  assign cmd_bank_o = bank_q;
  assign cmd_addr_o = addr_q;

  // R5
  inorder_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_orf_i && sel_vld) |-> (q_age[sel_idx] == '0));
  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_orf_i != $past(mode_orf_i)) |-> $past(q_empty));
  // R11
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(do_pre | do_act | do_col));
endmodule

// File: tb/tb_dram_sched.sv
module tb_dram_sched;
  localparam int NB = 4, BW = 2, RW = 8, CW = 6, AW = 8, DEPTH = 8, TRP = 2, TRCD = 3;
  localparam int C_NOP = 0, C_PRE = 1, C_ACT = 2, C_RD = 3, C_WR = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, mode, req_valid, req_write, req_ready;
  logic [BW-1:0] req_bank;
  logic [RW-1:0] req_row;
  logic [CW-1:0] req_col;
  logic [2:0]    cmd;
  logic [BW-1:0] cmd_bank;
  logic [AW-1:0] cmd_addr;

  dram_sched #(.NUM_BANKS(NB), .DEPTH(DEPTH), .ROW_W(RW), .COL_W(CW),
               .T_RP(TRP), .T_RCD(TRCD)) dut (
    .clk(clk), .rst_n(rst_n), .mode_orf_i(mode), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .req_bank_i(req_bank), .req_row_i(req_row),
    .req_col_i(req_col), .req_write_i(req_write), .cmd_o(cmd),
    .cmd_bank_o(cmd_bank), .cmd_addr_o(cmd_addr)
  );

  typedef struct { int bank; int row; int col; bit we; } mreq_t;
  typedef struct { int c; int b; int a; } obs_t;
  mreq_t mq[$];
  obs_t  obs[$];
  int m_open[NB], m_row[NB], m_tmr[NB];
  int exp_cmd, exp_bank, exp_addr;
  bit exp_ready, seen_full;
  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // behavioural reference, one step per clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_row[b] = 0; m_tmr[b] = 0; end
      exp_cmd = C_NOP; exp_bank = 0; exp_addr = 0; exp_ready = 1;
    end else begin
      int ph, pa, p, b;
      bit rdy_now;
      ph = -1; pa = -1;
      for (int i = 0; i < mq.size(); i++) begin
        int bk;
        if (!mode && i > 0) break;
        bk = mq[i].bank;
        if (m_tmr[bk] != 0) continue;
        if (m_open[bk] && m_row[bk] == mq[i].row && ph < 0) ph = i;
        if (pa < 0) pa = i;
      end
      p = (ph >= 0) ? ph : pa;
      rdy_now = (mq.size() < DEPTH);
      for (int k = 0; k < NB; k++) if (m_tmr[k] > 0) m_tmr[k]--;
      exp_cmd = C_NOP; exp_bank = 0; exp_addr = 0;
      if (p >= 0) begin
        b = mq[p].bank;
        exp_bank = b;
        if (m_open[b] && m_row[b] == mq[p].row) begin
          exp_cmd = mq[p].we ? C_WR : C_RD;
          exp_addr = mq[p].col;
          mq.delete(p);
        end else if (m_open[b]) begin
          exp_cmd = C_PRE; m_open[b] = 0; m_tmr[b] = TRP;
        end else begin
          exp_cmd = C_ACT; exp_addr = mq[p].row;
          m_open[b] = 1; m_row[b] = mq[p].row; m_tmr[b] = TRCD;
        end
      end
      if (req_valid && rdy_now)
        mq.push_back('{bank: int'(req_bank), row: int'(req_row), col: int'(req_col), we: req_write});
      exp_ready = (mq.size() < DEPTH);
    end
  end

  function automatic string tag_of(input int c);
    if (!mode) return "R5";
    case (c)
      C_PRE, C_ACT: return "R4 R8";
      C_RD, C_WR:   return "R2 R6 R7";
      default:      return "R11";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(cmd) == exp_cmd, {tag_of(exp_cmd), " cmd"}, int'(cmd), exp_cmd);
      chk(int'(cmd_bank) == exp_bank, "R11 cmd bank", int'(cmd_bank), exp_bank);
      chk(int'(cmd_addr) == exp_addr, "R3 cmd addr", int'(cmd_addr), exp_addr);
      chk(req_ready == exp_ready, "R9 ready", int'(req_ready), int'(exp_ready));
      if (!req_ready && mq.size() == DEPTH) seen_full = 1;
      if (cmd != 3'd0) obs.push_back('{c: int'(cmd), b: int'(cmd_bank), a: int'(cmd_addr)});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  task automatic send(input int b, input int r, input int c, input bit w);
    bit ok;
    req_valid = 1; req_bank = BW'(b); req_row = RW'(r); req_col = CW'(c); req_write = w;
    ok = 0;
    while (!ok) begin ok = req_ready; @(negedge clk); end
  endtask

  task automatic idle(input int n);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    int guard = 0;
    req_valid = 0;
    while (mq.size() != 0 && guard < 2000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
  endtask

  function automatic int col_pos(input int col, input int from);
    for (int i = from; i < obs.size(); i++)
      if ((obs[i].c == C_RD || obs[i].c == C_WR) && obs[i].a == col) return i;
    return -1;
  endfunction

  initial begin
    int base, p1, p2, p3;
    rst_n = 0; mode = 0; req_valid = 0; req_bank = '0; req_row = '0; req_col = '0;
    req_write = 0; seen_full = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd == 3'd0, "R1 cmd in reset", int'(cmd), 0);
    chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
    rst_n = 1;
    @(negedge clk);
    chk(cmd == 3'd0 && cmd_addr == '0, "R1 cmd after reset", int'(cmd), 0);

    // in-order phase: columns must follow arrival order
    base = obs.size();
    send(0, 1, 1, 0); send(1, 2, 2, 1); send(0, 3, 3, 0);
    send(0, 1, 4, 1); send(2, 4, 5, 0); send(1, 2, 6, 0);
    drain();
    p1 = base;
    for (int c = 1; c <= 6; c++) begin
      p2 = col_pos(c, base);
      chk(p2 >= p1, "R5 column order", p2, p1);
      p1 = p2;
    end

    // R10 mode switched only after drain
    chk(req_ready && cmd == 3'd0, "R10 idle before mode change", int'(cmd), 0);
    mode = 1;
    @(negedge clk);

    // R6: younger hit overtakes older miss on bank 0
    base = obs.size();
    send(0, 5, 12, 0); send(0, 9, 10, 0); send(0, 5, 11, 1);
    drain();
    p1 = col_pos(12, base); p2 = col_pos(11, base); p3 = col_pos(10, base);
    chk(p1 >= 0 && p1 < p2, "R7 oldest hit first", p1, p2);
    chk(p2 >= 0 && p2 < p3, "R6 hit before older miss", p2, p3);

    // R8: precharge on bank 1 while bank 3 waits after its activate
    base = obs.size();
    send(3, 1, 40, 0); send(1, 7, 41, 0);
    drain();
    p1 = -1;
    for (int i = base; i < obs.size(); i++)
      if (obs[i].c == C_PRE && obs[i].b == 1 && p1 < 0) p1 = i;
    p2 = col_pos(40, base);
    chk(p1 >= 0 && p1 < p2, "R8 overlap other bank", p1, p2);

    // R9: fill the queue with conflicting rows on one bank
    for (int k = 0; k < 10; k++) send(2, 1 + (k % 2), 50 + k, k[0]);
    drain();
    chk(seen_full, "R9 queue reached full", int'(seen_full), 1);

    // random open-row-first traffic
    for (int k = 0; k < 200; k++) begin
      send($urandom_range(0, NB - 1), $urandom_range(0, 3), $urandom_range(0, 63), $urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 4));
    end
    drain();

    // R10 switch back to in-order, random traffic
    chk(req_ready && cmd == 3'd0, "R10 idle before mode change", int'(cmd), 0);
    mode = 0;
    @(negedge clk);
    for (int k = 0; k < 150; k++) begin
      send($urandom_range(0, NB - 1), $urandom_range(0, 3), $urandom_range(0, 63), $urandom_range(0, 1));
      if ($urandom_range(0, 4) == 0) idle($urandom_range(1, 3));
    end
    drain();

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule